// File: doc/BRIEF.md
# Outstanding Atomic Operation Tracker

This block keeps per-line bookkeeping for atomic operations that a shared second-level cache sends on to the memory side instead of executing them itself. When an atomic reaches a line, the local copy is dropped, the atomic is forwarded downstream with the requester's ID and byte mask, and a per-line counter records how many atomics are in flight. Every downstream atomic response is routed back to the requester it names, a done message goes to the memory side, and the counter steps down.

Completion is not detected in the response path. When a response brings a counter to zero, the tracker queues a self-trigger for that line. The trigger is evaluated one cycle later and frees the line only if the count is still zero. While atomics are in flight, ordinary reads and writes to the line are refused so that the requester retries them. A dirty line is written back, and its acknowledgement is awaited, before any atomic may start on it. Invalidation probes are acknowledged at once and carry no data.

Top module: `atq_tracker`

## Requirements
- R1: After reset every line is invalid with a zero count, the trigger queue is empty, and all output valids are low.
- R2: An atomic (req_kind 2) to an invalid or valid line is accepted (req_retry low). dn_valid follows one cycle later with the request's line, ID and mask. The line becomes busy, so a later read (req_kind 0) or write (req_kind 1) to it sees req_retry high.
- R3: Each further atomic to a busy line is accepted and forwarded one cycle later, and it adds one to the line's count.
- R4: The count is 4 bits wide. An atomic to a busy line whose count is 15 is retried and produces no dn_valid.
- R5: An atomic to a dirty line is retried, and wb_valid with that line follows one cycle later. Until a response with rsp_is_ack high arrives for the line, every request to it is retried. That acknowledgement raises done_valid one cycle later and leaves the line invalid.
- R6: A data response (rsp_is_ack low) to a busy line with a nonzero count raises cr_valid one cycle later, carrying the response's ID, data and line. done_valid rises in the same cycle, and the count drops by one. Responses to lines that are not busy produce no output.
- R7: When a response brings a count to zero, the line stays busy for the following cycle and becomes invalid at the clock edge after that.
- R8: If an atomic to the same line is accepted in the cycle when a trigger is evaluated, the trigger is discarded and the line stays busy.
- R9: A probe gets prb_ack one cycle later, carrying the probed line. It changes neither the count nor the busy state. It invalidates a valid line, and leaves a dirty line dirty.
- R10: An accepted write makes the line dirty. An accepted read makes an invalid line valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_kind | input | 2 | 0 read, 1 write, 2 atomic |
| req_line | input | IDX_W | Line index of the request |
| req_id | input | ID_W | Requester ID |
| req_mask | input | MASK_W | Byte mask of the atomic |
| req_retry | output | 1 | Request refused this cycle, retry later |
| dn_valid | output | 1 | Forwarded atomic to the memory side |
| dn_line | output | IDX_W | Line of forwarded atomic |
| dn_id | output | ID_W | Original requester of forwarded atomic |
| dn_mask | output | MASK_W | Byte mask of forwarded atomic |
| wb_valid | output | 1 | Writeback request for a dirty line |
| wb_line | output | IDX_W | Line being written back |
| rsp_valid | input | 1 | Response from the memory side |
| rsp_is_ack | input | 1 | 1: writeback acknowledgement, 0: atomic data |
| rsp_line | input | IDX_W | Line of the response |
| rsp_id | input | ID_W | Requester the response is for |
| rsp_data | input | DATA_W | Atomic return data |
| cr_valid | output | 1 | Response to the core |
| cr_line | output | IDX_W | Line of core response |
| cr_id | output | ID_W | Destination requester |
| cr_data | output | DATA_W | Returned atomic data |
| done_valid | output | 1 | Done message to the memory side |
| done_line | output | IDX_W | Line of the done message |
| prb_valid | input | 1 | Invalidation probe |
| prb_line | input | IDX_W | Probed line |
| prb_ack | output | 1 | Probe acknowledgement without data |
| prb_ack_line | output | IDX_W | Line of probe acknowledgement |

## Verification
Directed sequences cover the main paths one at a time. One sequence takes a single atomic and runs it through its response. Another stacks three atomics and drains them, which tests the counting separately from simple busy tracking. Others fill a counter to 15, which exposes wrap-around against saturation, and put an atomic in the gap between the last response and trigger evaluation, which tests whether the deferred check really reads the live count. A dirty-line sequence tests the writeback-and-retry path. A long random phase then mixes requests, responses, stray responses and probes across four lines, often several on the same line in one cycle, and compares every output with a cycle model. This shows whether simultaneous increment, decrement, trigger and probe updates combine in the right priority.

// File: rtl/atq_pkg.sv
// Package: shared types for the outstanding atomic tracker.
// Assumes a line can be in exactly one of the listed states.
package atq_pkg;

    // Per-line state as seen by the tracker.
    typedef enum logic [2:0] {
        LN_INV    = 3'd0,
        LN_VALID  = 3'd1,
        LN_DIRTY  = 3'd2,
        LN_WBWAIT = 3'd3,
        LN_ATOMIC = 3'd4
    } line_st_t;

    // Core request encodings.
    localparam logic [1:0] RK_READ   = 2'd0;
    localparam logic [1:0] RK_WRITE  = 2'd1;
    localparam logic [1:0] RK_ATOMIC = 2'd2;

endpackage

// File: rtl/atq_trig_fifo.sv
// Module: atq_trig_fifo
// Small FIFO holding line indices of pending completion triggers.
// The head entry is consumed every cycle it is present; the owner
// guarantees no push when full.
module atq_trig_fifo #(
    parameter int DEPTH = 2,
    parameter int W     = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         head_valid,
    output logic [W-1:0] head_data,
    output logic         full
);
    logic [W-1:0]   mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [PTR_W:0]   used;
    logic             pop;

    assign head_valid = (used != '0);
    assign head_data  = mem[rd_ptr];
    assign full       = (used == (PTR_W+1)'(DEPTH));
    assign pop        = head_valid;

    // Pointer and occupancy update; reset empties the queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            used   <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            used <= used + (PTR_W+1)'(push) - (PTR_W+1)'(pop);
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end
endmodule

// File: rtl/atq_line_table.sv
// Module: atq_line_table
// Holds state and in-flight atomic count for every line, decides
// acceptance of core requests, consumes responses and evaluates the
// deferred completion trigger. Assumes one request, one response,
// one probe and one trigger at most per cycle.
module atq_line_table
    import atq_pkg::*;
#(
    parameter int LINES = 4,
    parameter int CNT_W = 4,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic [IDX_W-1:0] req_line,
    input  logic             rsp_valid,
    input  logic             rsp_is_ack,
    input  logic [IDX_W-1:0] rsp_line,
    input  logic             prb_valid,
    input  logic [IDX_W-1:0] prb_line,
    input  logic             trig_valid,
    input  logic [IDX_W-1:0] trig_line,
    output logic             req_retry,
    output logic             acc_atom,
    output logic             wb_issue,
    output logic             data_take,
    output logic             ack_take,
    output logic             trig_push
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    line_st_t   st_q  [LINES];
    logic [CNT_W-1:0] cnt_q [LINES];
    line_st_t   st_d  [LINES];
    logic [CNT_W-1:0] cnt_d [LINES];

    logic acc_wr, acc_rd;
    line_st_t req_st;
    logic [CNT_W-1:0] req_cnt;

    assign req_st  = st_q[req_line];
    assign req_cnt = cnt_q[req_line];

    // Next state of one line, highest-priority cause first.
    function automatic line_st_t next_line_state(
        line_st_t cur, logic h_atom, logic h_wr, logic h_wb, logic h_rd,
        logic h_ack, logic h_free, logic h_prb);
        if (h_atom)                            return LN_ATOMIC;
        else if (h_wr)                         return LN_DIRTY;
        else if (h_wb)                         return LN_WBWAIT;
        else if (h_rd && cur == LN_INV)        return LN_VALID;
        else if (h_ack || h_free)              return LN_INV;
        else if (h_prb && cur == LN_VALID)     return LN_INV;
        else                                   return cur;
    endfunction

    // Request acceptance decision from the addressed line's state.
    always_comb begin
        req_retry = 1'b0;
        acc_atom  = 1'b0;
        acc_wr    = 1'b0;
        acc_rd    = 1'b0;
        wb_issue  = 1'b0;
        if (req_valid) begin
            unique case (req_st)
                LN_WBWAIT: req_retry = 1'b1;
                LN_ATOMIC: begin
                    if (req_kind == RK_ATOMIC && req_cnt != CNT_MAX) acc_atom = 1'b1;
                    else req_retry = 1'b1;
                end
                LN_DIRTY: begin
                    if (req_kind == RK_ATOMIC) begin
                        req_retry = 1'b1;
                        wb_issue  = 1'b1;
                    end else if (req_kind == RK_WRITE) acc_wr = 1'b1;
                    else acc_rd = 1'b1;
                end
                default: begin
                    if (req_kind == RK_ATOMIC)     acc_atom = 1'b1;
                    else if (req_kind == RK_WRITE) acc_wr   = 1'b1;
                    else                           acc_rd   = 1'b1;
                end
            endcase
        end
    end

    // Response consumption: data needs a busy line with work in flight.
    assign data_take = rsp_valid && !rsp_is_ack &&
                       st_q[rsp_line] == LN_ATOMIC && cnt_q[rsp_line] != '0;
    assign ack_take  = rsp_valid && rsp_is_ack && st_q[rsp_line] == LN_WBWAIT;

    // Trigger is queued when the last in-flight atomic of a line returns.
    assign trig_push = data_take && cnt_q[rsp_line] == CNT_W'(1) &&
                       !(acc_atom && req_line == rsp_line);

    // Per-line next-value decode.
    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic hit_req, inc, dec, freed;
        assign hit_req = (req_line == IDX_W'(i));
        assign inc     = acc_atom && hit_req;
        assign dec     = data_take && (rsp_line == IDX_W'(i));
        assign freed   = trig_valid && (trig_line == IDX_W'(i)) &&
                         st_q[i] == LN_ATOMIC && cnt_q[i] == '0 && !inc;
        assign cnt_d[i] = cnt_q[i] + CNT_W'(inc) - CNT_W'(dec);
        assign st_d[i]  = next_line_state(st_q[i], inc, acc_wr && hit_req,
                                          wb_issue && hit_req, acc_rd && hit_req,
                                          ack_take && (rsp_line == IDX_W'(i)),
                                          freed,
                                          prb_valid && (prb_line == IDX_W'(i)));
    end

    // Line state and count registers; reset invalidates all lines.
    always_ff @(posedge clk) begin
        for (int k = 0; k < LINES; k++) begin
            if (!rst_n) begin
                st_q[k]  <= LN_INV;
                cnt_q[k] <= '0;
            end else begin
                st_q[k]  <= st_d[k];
                cnt_q[k] <= cnt_d[k];
            end
        end
    end
endmodule

// File: rtl/atq_out_regs.sv
// Module: atq_out_regs
// Registers every outgoing message so each appears exactly one cycle
// after the decision that produced it. Assumes the response data and
// writeback-ack takes are mutually exclusive.
module atq_out_regs #(
    parameter int IDX_W  = 2,
    parameter int ID_W   = 4,
    parameter int MASK_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_atom,
    input  logic              wb_issue,
    input  logic              data_take,
    input  logic              ack_take,
    input  logic              prb_valid,
    input  logic [IDX_W-1:0]  req_line,
    input  logic [ID_W-1:0]   req_id,
    input  logic [MASK_W-1:0] req_mask,
    input  logic [IDX_W-1:0]  rsp_line,
    input  logic [ID_W-1:0]   rsp_id,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic [IDX_W-1:0]  prb_line,
    output logic              dn_valid,
    output logic [IDX_W-1:0]  dn_line,
    output logic [ID_W-1:0]   dn_id,
    output logic [MASK_W-1:0] dn_mask,
    output logic              wb_valid,
    output logic [IDX_W-1:0]  wb_line,
    output logic              cr_valid,
    output logic [IDX_W-1:0]  cr_line,
    output logic [ID_W-1:0]   cr_id,
    output logic [DATA_W-1:0] cr_data,
    output logic              done_valid,
    output logic [IDX_W-1:0]  done_line,
    output logic              prb_ack,
    output logic [IDX_W-1:0]  prb_ack_line
);
    // Valid strobes, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_valid   <= 1'b0;
            wb_valid   <= 1'b0;
            cr_valid   <= 1'b0;
            done_valid <= 1'b0;
            prb_ack    <= 1'b0;
        end else begin
            dn_valid   <= acc_atom;
            wb_valid   <= wb_issue;
            cr_valid   <= data_take;
            done_valid <= data_take || ack_take;
            prb_ack    <= prb_valid;
        end
    end

    // Payload fields, captured with their strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_line <= '0; dn_id <= '0; dn_mask <= '0; wb_line <= '0;
            cr_line <= '0; cr_id <= '0; cr_data <= '0;
            done_line <= '0; prb_ack_line <= '0;
        end else begin
            if (acc_atom) begin
                dn_line <= req_line;
                dn_id   <= req_id;
                dn_mask <= req_mask;
            end
            if (wb_issue) wb_line <= req_line;
            if (data_take) begin
                cr_line <= rsp_line;
                cr_id   <= rsp_id;
                cr_data <= rsp_data;
            end
            if (data_take || ack_take) done_line <= rsp_line;
            if (prb_valid) prb_ack_line <= prb_line;
        end
    end
endmodule

// File: rtl/atq_tracker.sv
// Module: atq_tracker (top)
// Tracks atomics forwarded downstream per cache line, returns their
// data to requesters and frees the line through a deferred trigger.
// Assumes at most one request, response and probe per cycle.
module atq_tracker #(
    parameter int LINES      = 4,
    parameter int ID_W       = 4,
    parameter int MASK_W     = 8,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 4,
    parameter int TRIG_DEPTH = 2,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [IDX_W-1:0]  req_line,
    input  logic [ID_W-1:0]   req_id,
    input  logic [MASK_W-1:0] req_mask,
    output logic              req_retry,
    output logic              dn_valid,
    output logic [IDX_W-1:0]  dn_line,
    output logic [ID_W-1:0]   dn_id,
    output logic [MASK_W-1:0] dn_mask,
    output logic              wb_valid,
    output logic [IDX_W-1:0]  wb_line,
    input  logic              rsp_valid,
    input  logic              rsp_is_ack,
    input  logic [IDX_W-1:0]  rsp_line,
    input  logic [ID_W-1:0]   rsp_id,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              cr_valid,
    output logic [IDX_W-1:0]  cr_line,
    output logic [ID_W-1:0]   cr_id,
    output logic [DATA_W-1:0] cr_data,
    output logic              done_valid,
    output logic [IDX_W-1:0]  done_line,
    input  logic              prb_valid,
    input  logic [IDX_W-1:0]  prb_line,
    output logic              prb_ack,
    output logic [IDX_W-1:0]  prb_ack_line
);
    logic acc_atom, wb_issue, data_take, ack_take;
    logic trig_push, trig_full, trig_valid;
    logic [IDX_W-1:0] trig_line;

    atq_line_table #(.LINES(LINES), .CNT_W(CNT_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_kind(req_kind), .req_line(req_line),
        .rsp_valid(rsp_valid), .rsp_is_ack(rsp_is_ack), .rsp_line(rsp_line),
        .prb_valid(prb_valid), .prb_line(prb_line),
        .trig_valid(trig_valid), .trig_line(trig_line),
        .req_retry(req_retry), .acc_atom(acc_atom), .wb_issue(wb_issue),
        .data_take(data_take), .ack_take(ack_take), .trig_push(trig_push)
    );

    atq_trig_fifo #(.DEPTH(TRIG_DEPTH), .W(IDX_W)) u_trig (
        .clk(clk), .rst_n(rst_n),
        .push(trig_push), .push_data(rsp_line),
        .head_valid(trig_valid), .head_data(trig_line), .full(trig_full)
    );

    atq_out_regs #(.IDX_W(IDX_W), .ID_W(ID_W), .MASK_W(MASK_W), .DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n),
        .acc_atom(acc_atom), .wb_issue(wb_issue), .data_take(data_take),
        .ack_take(ack_take), .prb_valid(prb_valid),
        .req_line(req_line), .req_id(req_id), .req_mask(req_mask),
        .rsp_line(rsp_line), .rsp_id(rsp_id), .rsp_data(rsp_data),
        .prb_line(prb_line),
        .dn_valid(dn_valid), .dn_line(dn_line), .dn_id(dn_id), .dn_mask(dn_mask),
        .wb_valid(wb_valid), .wb_line(wb_line),
        .cr_valid(cr_valid), .cr_line(cr_line), .cr_id(cr_id), .cr_data(cr_data),
        .done_valid(done_valid), .done_line(done_line),
        .prb_ack(prb_ack), .prb_ack_line(prb_ack_line)
    );
endmodule

// File: rtl/atq_tracker_chk.sv
// Module: atq_tracker_chk
// Temporal checks on the tracker's ports and trigger queue, bound
// to every atq_tracker instance.
module atq_tracker_chk #(
    parameter int IDX_W = 2,
    parameter int ID_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [1:0]       req_kind,
    input logic [IDX_W-1:0] req_line,
    input logic             req_retry,
    input logic             dn_valid,
    input logic [IDX_W-1:0] dn_line,
    input logic             wb_valid,
    input logic             rsp_valid,
    input logic             rsp_is_ack,
    input logic [ID_W-1:0]  rsp_id,
    input logic             cr_valid,
    input logic [ID_W-1:0]  cr_id,
    input logic             done_valid,
    input logic             prb_valid,
    input logic [IDX_W-1:0] prb_line,
    input logic             prb_ack,
    input logic [IDX_W-1:0] prb_ack_line,
    input logic             trig_push,
    input logic             trig_full
);
    AST_DN_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> $past(req_valid && req_kind == 2'd2 && !req_retry) && dn_line == $past(req_line)); // R2
    AST_RETRY_NO_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_retry) |=> !dn_valid); // R4
    AST_WB_ON_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(req_valid && req_retry && req_kind == 2'd2)); // R5
    AST_CR_FROM_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        cr_valid |-> $past(rsp_valid && !rsp_is_ack) && cr_id == $past(rsp_id)); // R6
    AST_CR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        cr_valid |-> done_valid); // R6
    AST_PROBE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        prb_valid |=> prb_ack && prb_ack_line == $past(prb_line)); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        trig_push |-> !trig_full); // R7
endmodule

bind atq_tracker atq_tracker_chk #(.IDX_W(IDX_W), .ID_W(ID_W)) chk_i (.*);

// File: tb/atq_tracker_tb.sv
// Bench: directed corner cases then seeded random traffic, compared
// against a cycle model written from the requirements.
module atq_tracker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LINES = 4;
    localparam int IW = 2;
    localparam int ST_INV = 0, ST_VAL = 1, ST_DRT = 2, ST_WBW = 3, ST_ATM = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0; logic [1:0] req_kind = 0; logic [IW-1:0] req_line = 0;
    logic [3:0] req_id = 0; logic [7:0] req_mask = 0; logic req_retry;
    logic dn_valid; logic [IW-1:0] dn_line; logic [3:0] dn_id; logic [7:0] dn_mask;
    logic wb_valid; logic [IW-1:0] wb_line;
    logic rsp_valid = 0, rsp_is_ack = 0; logic [IW-1:0] rsp_line = 0;
    logic [3:0] rsp_id = 0; logic [31:0] rsp_data = 0;
    logic cr_valid; logic [IW-1:0] cr_line; logic [3:0] cr_id; logic [31:0] cr_data;
    logic done_valid; logic [IW-1:0] done_line;
    logic prb_valid = 0; logic [IW-1:0] prb_line = 0;
    logic prb_ack; logic [IW-1:0] prb_ack_line;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    int m_st [LINES];
    int m_cnt [LINES];
    bit m_trig; int m_tline;

    always #(CLK_PERIOD/2) clk = ~clk;

    atq_tracker dut_i (.*);

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check retry, then check registered outputs.
    task automatic step(input string tag, input bit rv, input int kind, input int line,
                        input int id, input int mask, input bit sv, input bit ack,
                        input int sline, input int sid, input int sdata,
                        input bit pv, input int pline);
        int ns [LINES]; int nc [LINES];
        bit e_retry, acc_at, acc_wr, acc_rd, e_wb, tk_d, tk_a, freed, push;
        req_valid = rv; req_kind = kind[1:0]; req_line = line[IW-1:0];
        req_id = id[3:0]; req_mask = mask[7:0];
        rsp_valid = sv; rsp_is_ack = ack; rsp_line = sline[IW-1:0];
        rsp_id = sid[3:0]; rsp_data = sdata;
        prb_valid = pv; prb_line = pline[IW-1:0];
        e_retry = 0; acc_at = 0; acc_wr = 0; acc_rd = 0; e_wb = 0;
        if (rv) begin
            case (m_st[line])
                ST_WBW: e_retry = 1;
                ST_ATM: if (kind == 2 && m_cnt[line] != 15) acc_at = 1; else e_retry = 1;
                ST_DRT: if (kind == 2) begin e_retry = 1; e_wb = 1; end
                        else if (kind == 1) acc_wr = 1; else acc_rd = 1;
                default: if (kind == 2) acc_at = 1; else if (kind == 1) acc_wr = 1; else acc_rd = 1;
            endcase
        end
        tk_d = sv && !ack && m_st[sline] == ST_ATM && m_cnt[sline] > 0;
        tk_a = sv && ack && m_st[sline] == ST_WBW;
        freed = m_trig && m_st[m_tline] == ST_ATM && m_cnt[m_tline] == 0 &&
                !(acc_at && line == m_tline);
        ns = m_st; nc = m_cnt;
        if (acc_at) nc[line] = nc[line] + 1;
        if (tk_d) nc[sline] = nc[sline] - 1;
        push = tk_d && nc[sline] == 0;
        for (int l = 0; l < LINES; l++) begin
            bit hit;
            hit = rv && line == l && (acc_at || acc_wr || e_wb || (acc_rd && m_st[l] == ST_INV));
            if (hit) ns[l] = acc_at ? ST_ATM : acc_wr ? ST_DRT : e_wb ? ST_WBW : ST_VAL;
            else if (tk_a && sline == l) ns[l] = ST_INV;
            else if (freed && m_tline == l) ns[l] = ST_INV;
            else if (pv && pline == l && m_st[l] == ST_VAL) ns[l] = ST_INV;
        end
        #1;
        check(tag, "req_retry", req_retry, e_retry);
        m_st = ns; m_cnt = nc; m_trig = push; m_tline = sline;
        @(posedge clk); @(negedge clk);
        check(tag, "dn_valid", dn_valid, acc_at);
        if (acc_at) check(tag, "dn fields", {dn_line, dn_id, dn_mask}, {line[IW-1:0], id[3:0], mask[7:0]});
        check(tag, "wb_valid", wb_valid, e_wb);
        if (e_wb) check(tag, "wb_line", wb_line, line);
        check(tag, "cr_valid", cr_valid, tk_d);
        if (tk_d) check(tag, "cr fields", {cr_line, cr_id, cr_data}, {sline[IW-1:0], sid[3:0], sdata[31:0]});
        check(tag, "done_valid", done_valid, tk_d || tk_a);
        if (tk_d || tk_a) check(tag, "done_line", done_line, sline);
        check(tag, "prb_ack", prb_ack, pv);
        if (pv) check(tag, "prb_ack_line", prb_ack_line, pline);
    endtask

    task automatic req(input string tag, input int kind, input int line, input int id, input int mask);
        step(tag, 1, kind, line, id, mask, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic rsp(input string tag, input bit ack, input int line, input int id, input int data);
        step(tag, 0, 0, 0, 0, 0, 1, ack, line, id, data, 0, 0);
    endtask
    task automatic idle(input string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int l = 0; l < LINES; l++) begin m_st[l] = ST_INV; m_cnt[l] = 0; end
        m_trig = 0; m_tline = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: all outputs idle after reset
        check("R1", "valids after reset", {dn_valid, wb_valid, cr_valid, done_valid, prb_ack}, 0);
        idle("R1");
        // R2: single atomic forwarded, then reads to the line retried
        req("R2", 2, 0, 5, 8'hA5);
        req("R2", 0, 0, 1, 0);
        // R3: two more atomics counted
        req("R3", 2, 0, 6, 8'h0F);
        req("R3", 2, 0, 7, 8'hF0);
        // R9: probe acked, line stays busy
        step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        req("R9", 1, 0, 1, 0);
        // R6: three responses returned to named requesters
        rsp("R6", 0, 0, 5, 32'h1111);
        rsp("R6", 0, 0, 6, 32'h2222);
        rsp("R6", 0, 0, 7, 32'h3333);
        // R7: busy one cycle after the last response, free after
        req("R7", 0, 0, 2, 0);
        req("R7", 0, 0, 2, 0);
        rsp("R6", 0, 0, 3, 32'h4444);   // stray response, no output
        // R4: saturate count at 15 on line 1
        for (int k = 0; k < 15; k++) req("R4", 2, 1, k, k);
        req("R4", 2, 1, 9, 1);
        for (int k = 0; k < 15; k++) rsp("R4", 0, 1, k, k + 100);
        idle("R4"); idle("R4");
        // R8: atomic in the trigger-evaluation cycle keeps line busy
        req("R8", 2, 2, 3, 3);
        rsp("R8", 0, 2, 3, 32'h55);
        req("R8", 2, 2, 4, 4);
        idle("R8"); idle("R8");
        req("R8", 0, 2, 1, 0);
        rsp("R8", 0, 2, 4, 32'h66);
        idle("R8"); idle("R8");
        // R10 / R5: write makes line dirty, atomic forces writeback
        req("R10", 1, 3, 1, 8'hFF);
        step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 3);
        req("R5", 2, 3, 2, 8'h01);
        req("R5", 0, 3, 2, 0);
        rsp("R5", 0, 3, 2, 32'h77);
        rsp("R5", 1, 3, 0, 0);
        req("R5", 2, 3, 2, 8'h01);
        rsp("R5", 0, 3, 2, 32'h88);
        idle("R5"); idle("R5");
        // R10: read on invalid line makes it valid, probe invalidates
        req("R10", 0, 1, 0, 0);
        step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
        // Random mixed traffic
        for (int c = 0; c < 3000; c++) begin
            int sl; bit ack;
            sl = $urandom_range(LINES-1);
            ack = (m_st[sl] == ST_WBW) ? ($urandom_range(3) != 0) : ($urandom_range(15) == 0);
            step("RND", $urandom_range(2) != 0, $urandom_range(2), $urandom_range(LINES-1),
                 $urandom_range(15), $urandom_range(255),
                 $urandom_range(1), ack, sl, $urandom_range(15), $urandom,
                 $urandom_range(5) == 0, $urandom_range(LINES-1));
        end
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule